// File: doc/BRIEF.md
# Dual-Port Paged ROM Address Translator

This block turns CPU read addresses into physical ROM addresses for two processors that share one cartridge ROM. A table of eight page registers, each naming a 512 KiB ROM page, is the single source of truth for both sides. The primary processor sees ROM through a 1 MiB window at 0x900000–0x9FFFFF. A 2-bit window-select register picks which pair of table entries backs the two 512 KiB halves of that window. The secondary processor indexes the table straight from its address bits [21:19], so it sees the whole paged space at once.

A mode input selects paged operation or a plain linear layout. In linear layout the primary window is a contiguous 1 MiB slice of ROM chosen by the window register, and it is bounded by the ROM size. The secondary port then passes its address through untouched. Page and window registers are loaded from a byte/word write bus. Every bank update can raise a one-cycle invalidate pulse, which downstream caches of translated code use to drop stale entries.

Top module: `paged_rom_xlat`

## Requirements
- R1: After reset, table entry i holds page i, the window register holds 0 and `inv_pulse` is low.
- R2: In paged mode the secondary ROM address is (entry[s_addr[21:19]] << 19) + s_addr[18:0]. A word read (`s_word`=1) forces bit 0 of the result to 0.
- R3: In paged mode a primary address in the window always hits. Offsets 0x00000–0x7FFFF of the window use entry 2·sel and offsets 0x80000–0xFFFFF use entry 2·sel+1, with the offset inside the half kept in bits [18:0]. A word read clears bit 0.
- R4: A byte write to an odd address 0xA130F3–0xA130FF loads the low `PG_W` bits of `wr_data[7:0]` into entry `wr_addr[3:1]`. Any access in the cycle after the write strobe sees the new value.
- R5: Entry 0 always selects page 0. A byte write to 0xA130F1 leaves the table unchanged, and so does a byte write to an even address in 0xA130F0–0xA130FF.
- R6: A word write to any address in 0xA130F0–0xA130FF acts as a byte write of `wr_data[7:0]` to that address with bit 0 set.
- R7: The window register loads `wr_data[1:0]` on a byte write to `WIN_ADDR`+1 or on a word write to `WIN_ADDR` (default 0xA15104). It keeps its value otherwise.
- R8: In linear mode the primary ROM address is sel·0x100000 + p_addr[19:0]. The port hits only when that address is below the ROM size rounded up to a multiple of 64 KiB.
- R9: In linear mode the secondary ROM address is s_addr[21:0] zero-extended, with bit 0 cleared on a word read.
- R10: A primary address outside 0x900000–0x9FFFFF never hits.
- R11: While `rom_cached` is high, `inv_pulse` is high for one cycle in the cycle after each of these events: a page-range write (odd-byte or word), a window write that changes the value, or `update_req`. It stays low after a window write of the stored value, and it stays low when `rom_cached` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paged_mode | input | 1 | 1 = paged translation, 0 = linear layout |
| rom_cached | input | 1 | Enables invalidate pulses |
| rom_size | input | PA_W+1 | ROM size in bytes |
| update_req | input | 1 | Request to re-evaluate both ports |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_addr | input | 24 | Write address |
| wr_data | input | 16 | Write data |
| p_addr | input | 24 | Primary read address |
| p_word | input | 1 | Primary word read |
| p_hit | output | 1 | Primary address maps to ROM |
| p_rom_addr | output | PA_W | Primary physical ROM address |
| s_addr | input | 24 | Secondary read address |
| s_word | input | 1 | Secondary word read |
| s_rom_addr | output | PA_W | Secondary physical ROM address |
| inv_pulse | output | 1 | One-cycle cache invalidate |

## Verification
The assertions check these on every cycle:
- the gating and sourcing of the invalidate pulse, including its absence after a window write that does not change the value;
- the loading and holding of the window register;
- the fixed page 0 on entry 0;
- the in-page offset and word alignment on the secondary port;
- the primary hit rules in paged mode and outside the window.

Only the bench scenarios can show the full address arithmetic: the half-window entry choice for each window value, the effect of word writes on the table, and the linear boundary against a rounded, non-aligned ROM size.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int CPU_AW   = 24;
  localparam int PG_OFS_W = 19;
  localparam int SEL_W    = 2;
  localparam int IDX_W    = 3;
  localparam int N_ENT    = 1 << IDX_W;
  localparam int BANK_SH  = 16;
  localparam logic [19:0] PG_REG_BASE = 20'hA130F;
  localparam logic [3:0]  WIN_TOP     = 4'h9;

  function automatic logic [IDX_W-1:0] half_index(input logic [SEL_W-1:0] sel,
                                                  input logic hi);
    return {sel, hi};
  endfunction
endpackage

// File: rtl/prom_regs.sv
module prom_regs
  import prom_pkg::*;
#(
  parameter int PG_W = 5,
  parameter logic [CPU_AW-1:0] WIN_ADDR = 24'hA15104
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_word,
  input  logic [CPU_AW-1:0]    wr_addr,
  input  logic [15:0]          wr_data,
  input  logic                 update_req,
  input  logic                 rom_cached,
  output logic [PG_W-1:0]      page_tbl [N_ENT],
  output logic [SEL_W-1:0]     win_sel,
  output logic                 pg_evt,
  output logic                 win_chg_evt,
  output logic                 inv_pulse
);
  logic in_pg_range, pg_byte_hit, pg_word_hit, win_byte, win_word;
  logic [IDX_W-1:0] pg_idx;
  logic [SEL_W-1:0] win_new;

  assign in_pg_range = (wr_addr[CPU_AW-1:4] == PG_REG_BASE);
  assign pg_byte_hit = wr_en && !wr_word && wr_addr[0] && in_pg_range;
  assign pg_word_hit = wr_en && wr_word && in_pg_range;
  assign pg_evt      = pg_byte_hit || pg_word_hit;
  assign pg_idx      = wr_addr[IDX_W:1];

  assign win_byte    = wr_en && !wr_word && (wr_addr == (WIN_ADDR | 24'h1));
  assign win_word    = wr_en && wr_word && (wr_addr == WIN_ADDR);
  assign win_new     = wr_data[SEL_W-1:0];
  assign win_chg_evt = (win_byte || win_word) && (win_new != win_sel);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    if (i == 0) begin : g_fixed
      assign page_tbl[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          page_tbl[i] <= PG_W'(i);
        else if (pg_evt && pg_idx == IDX_W'(i))
          page_tbl[i] <= wr_data[PG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      win_sel <= '0;
    else if (win_byte || win_word)
      win_sel <= win_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      inv_pulse <= 1'b0;
    else
      inv_pulse <= rom_cached && (pg_evt || win_chg_evt || update_req);
  end
endmodule

// File: rtl/prom_prim_xlat.sv
module prom_prim_xlat
  import prom_pkg::*;
#(
  parameter int PG_W = 5,
  localparam int PA_W = PG_W + PG_OFS_W
) (
  input  logic [PG_W-1:0]   page_tbl [N_ENT],
  input  logic [SEL_W-1:0]  win_sel,
  input  logic              paged_mode,
  input  logic [PA_W:0]     rom_size,
  input  logic [CPU_AW-1:0] p_addr,
  input  logic              p_word,
  output logic              p_hit,
  output logic [PA_W-1:0]   p_rom_addr
);
  localparam logic [PA_W+1:0] BANK_MASK =
    {{(PA_W+2-BANK_SH){1'b0}}, {BANK_SH{1'b1}}};

  function automatic logic [PA_W+1:0] round_up(input logic [PA_W:0] rs);
    logic [PA_W+1:0] t;
    t = {1'b0, rs} + BANK_MASK;
    return t & ~BANK_MASK;
  endfunction

  logic            in_win, lin_hit;
  logic [PA_W-1:0] paged_addr, raw;
  logic [PA_W:0]   lin_addr;

  assign in_win     = (p_addr[CPU_AW-1:20] == WIN_TOP);
  assign paged_addr = {page_tbl[half_index(win_sel, p_addr[19])], p_addr[PG_OFS_W-1:0]};
  assign lin_addr   = (PA_W+1)'({win_sel, p_addr[19:0]});
  assign lin_hit    = ({1'b0, lin_addr} < round_up(rom_size));
  assign p_hit      = in_win && (paged_mode || lin_hit);
  assign raw        = paged_mode ? paged_addr : lin_addr[PA_W-1:0];
  assign p_rom_addr = {raw[PA_W-1:1], raw[0] & ~p_word};
endmodule

// File: rtl/prom_sec_xlat.sv
module prom_sec_xlat
  import prom_pkg::*;
#(
  parameter int PG_W = 5,
  localparam int PA_W = PG_W + PG_OFS_W
) (
  input  logic [PG_W-1:0]   page_tbl [N_ENT],
  input  logic              paged_mode,
  input  logic [CPU_AW-1:0] s_addr,
  input  logic              s_word,
  output logic [PA_W-1:0]   s_rom_addr
);
  logic [PA_W-1:0] paged_addr, lin_addr, raw;

  assign paged_addr = {page_tbl[s_addr[PG_OFS_W+IDX_W-1:PG_OFS_W]], s_addr[PG_OFS_W-1:0]};
  assign lin_addr   = PA_W'(s_addr[PG_OFS_W+IDX_W-1:0]);
  assign raw        = paged_mode ? paged_addr : lin_addr;
  assign s_rom_addr = {raw[PA_W-1:1], raw[0] & ~s_word};
endmodule

// File: rtl/paged_rom_xlat.sv
module paged_rom_xlat
  import prom_pkg::*;
#(
  parameter int PG_W = 5,
  parameter logic [23:0] WIN_ADDR = 24'hA15104,
  localparam int PA_W = PG_W + PG_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paged_mode,
  input  logic              rom_cached,
  input  logic [PA_W:0]     rom_size,
  input  logic              update_req,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [23:0]       wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [23:0]       p_addr,
  input  logic              p_word,
  output logic              p_hit,
  output logic [PA_W-1:0]   p_rom_addr,
  input  logic [23:0]       s_addr,
  input  logic              s_word,
  output logic [PA_W-1:0]   s_rom_addr,
  output logic              inv_pulse
);
  logic [PG_W-1:0]  page_tbl [N_ENT];
  logic [SEL_W-1:0] win_sel;
  logic             pg_evt, win_chg_evt;

  prom_regs #(.PG_W(PG_W), .WIN_ADDR(WIN_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .update_req(update_req),
    .rom_cached(rom_cached), .page_tbl(page_tbl), .win_sel(win_sel),
    .pg_evt(pg_evt), .win_chg_evt(win_chg_evt), .inv_pulse(inv_pulse)
  );

  prom_prim_xlat #(.PG_W(PG_W)) prim_i (
    .page_tbl(page_tbl), .win_sel(win_sel), .paged_mode(paged_mode),
    .rom_size(rom_size), .p_addr(p_addr), .p_word(p_word),
    .p_hit(p_hit), .p_rom_addr(p_rom_addr)
  );

  prom_sec_xlat #(.PG_W(PG_W)) sec_i (
    .page_tbl(page_tbl), .paged_mode(paged_mode), .s_addr(s_addr),
    .s_word(s_word), .s_rom_addr(s_rom_addr)
  );
endmodule

// File: rtl/prom_xlat_chk.sv
module prom_xlat_chk #(
  parameter int PG_W = 5,
  parameter logic [23:0] WIN_ADDR = 24'hA15104,
  localparam int PA_W = PG_W + 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            paged_mode,
  input logic            rom_cached,
  input logic            update_req,
  input logic            wr_en,
  input logic            wr_word,
  input logic [23:0]     wr_addr,
  input logic [15:0]     wr_data,
  input logic [23:0]     p_addr,
  input logic            p_hit,
  input logic [23:0]     s_addr,
  input logic            s_word,
  input logic [PA_W-1:0] s_rom_addr,
  input logic            inv_pulse,
  input logic [1:0]      win_sel,
  input logic            pg_evt,
  input logic            win_chg_evt
);
  logic win_wr;
  assign win_wr = wr_en && ((wr_word && wr_addr == WIN_ADDR) ||
                            (!wr_word && wr_addr == (WIN_ADDR | 24'h1)));

  p_inv_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cached && (pg_evt || win_chg_evt || update_req) |=> inv_pulse);
  p_inv_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cached |=> !inv_pulse);
  p_win_same_r11: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && (wr_data[1:0] == win_sel) && !update_req |=> !inv_pulse);
  p_win_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(win_sel));
  p_win_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> win_sel == $past(wr_data[1:0]));
  p_ent0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    paged_mode && s_addr[21:19] == 3'd0 |-> s_rom_addr[PA_W-1:19] == '0);
  p_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_rom_addr[18:1] == s_addr[18:1]);
  p_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_word |-> !s_rom_addr[0]);
  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    p_addr[23:20] != 4'h9 |-> !p_hit);
  p_paged_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    paged_mode && p_addr[23:20] == 4'h9 |-> p_hit);
endmodule

bind paged_rom_xlat prom_xlat_chk #(.PG_W(PG_W), .WIN_ADDR(WIN_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .paged_mode(paged_mode), .rom_cached(rom_cached),
  .update_req(update_req), .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr),
  .wr_data(wr_data), .p_addr(p_addr), .p_hit(p_hit), .s_addr(s_addr),
  .s_word(s_word), .s_rom_addr(s_rom_addr), .inv_pulse(inv_pulse),
  .win_sel(win_sel), .pg_evt(pg_evt), .win_chg_evt(win_chg_evt)
);

// File: tb/paged_rom_xlat_tb_top.sv
module paged_rom_xlat_tb_top;
  localparam int PG_W = 5;
  localparam int PA_W = PG_W + 19;
  localparam int PAGE = 524288;
  localparam int MIB  = 1048576;

  logic clk = 0, rst_n = 0, paged_mode = 1, rom_cached = 1, update_req = 0;
  logic [PA_W:0] rom_size = '0;
  logic wr_en = 0, wr_word = 0;
  logic [23:0] wr_addr = '0, p_addr = '0, s_addr = '0;
  logic [15:0] wr_data = '0;
  logic p_word = 0, s_word = 0, p_hit, inv_pulse;
  logic [PA_W-1:0] p_rom_addr, s_rom_addr;

  int n_chk = 0, n_fail = 0;
  int tbl [8];
  int win = 0;

  always #5 clk = ~clk;

  paged_rom_xlat #(.PG_W(PG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .paged_mode(paged_mode), .rom_cached(rom_cached),
    .rom_size(rom_size), .update_req(update_req), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .p_addr(p_addr), .p_word(p_word),
    .p_hit(p_hit), .p_rom_addr(p_rom_addr), .s_addr(s_addr), .s_word(s_word),
    .s_rom_addr(s_rom_addr), .inv_pulse(inv_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus write; returns after the pulse cycle, inputs idle again
  task automatic bus_wr(input bit word, input int addr, input int data, input bit exp_inv,
                        input string tag);
    @(negedge clk);
    wr_en = 1; wr_word = word; wr_addr = addr[23:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 0;
    chk(inv_pulse == exp_inv, tag, int'(inv_pulse), int'(exp_inv));
    @(negedge clk);
    chk(inv_pulse == 1'b0, "R11 pulse width", int'(inv_pulse), 0);
  endtask

  task automatic model_pg(input bit word, input int addr, input int data);
    int idx;
    if ((addr >> 4) == 'hA130F && (word || (addr % 2) == 1)) begin
      idx = (addr % 16) / 2;
      if (idx != 0) tbl[idx] = data % 256 % 32;
    end
  endtask

  task automatic sec_probe(input int idx, input int ofs, input bit word, input string tag);
    int exp;
    @(negedge clk);
    s_addr = 24'(idx * PAGE + ofs); s_word = word;
    #1;
    exp = (paged_mode ? tbl[idx] : idx) * PAGE + ofs - (word ? ofs % 2 : 0);
    chk(int'(s_rom_addr) == exp, tag, int'(s_rom_addr), exp);
  endtask

  task automatic prim_probe(input int off, input bit word, input int rs_round, input string tag);
    int exp, exph;
    @(negedge clk);
    p_addr = 24'('h900000 + off); p_word = word;
    #1;
    if (paged_mode) begin
      exp = tbl[win * 2 + off / PAGE] * PAGE + off % PAGE;
      exph = 1;
    end else begin
      exp = win * MIB + off;
      exph = (exp < rs_round) ? 1 : 0;
    end
    if (word) exp = exp - exp % 2;
    chk(int'(p_hit) == exph, {tag, " hit"}, int'(p_hit), exph);
    if (exph == 1) chk(int'(p_rom_addr) == exp, tag, int'(p_rom_addr), exp);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ofs_set [3] = '{0, 'h7FFFF, 'h12345};
    int rs_round;
    for (int i = 0; i < 8; i++) tbl[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(inv_pulse == 0, "R1 inv", int'(inv_pulse), 0);
    for (int i = 0; i < 8; i++) sec_probe(i, 'h100, 0, "R1 identity");
    prim_probe('h00010, 0, 0, "R1 window0 lo");
    prim_probe('h80010, 0, 0, "R1 window0 hi");

    // R4 byte writes to entries 1..7, R11 pulse each
    for (int i = 1; i < 8; i++) begin
      bus_wr(0, 'hA130F1 + 2 * i, 'h40 + i * 3 + 5, 1, "R4/R11 page write pulse");
      model_pg(0, 'hA130F1 + 2 * i, 'h40 + i * 3 + 5);
    end
    // R5: control register write and even-byte write leave the table alone
    bus_wr(0, 'hA130F1, 'h1F, 1, "R11 ctrl write pulse");
    @(negedge clk); wr_en = 1; wr_word = 0; wr_addr = 24'hA130F4; wr_data = 16'h001E;
    @(negedge clk); wr_en = 0;
    sec_probe(0, 'h55, 0, "R5 entry0 fixed");
    sec_probe(2, 'h55, 0, "R5 even byte ignored");
    // R6: word write acts on low byte at addr|1
    bus_wr(1, 'hA130F6, 'hAB12, 1, "R6/R11 word write pulse");
    model_pg(1, 'hA130F6, 'hAB12);
    sec_probe(3, 'h4, 0, "R6 word write entry3");
    bus_wr(1, 'hA130FE, 'h5509, 1, "R6 word write pulse");
    model_pg(1, 'hA130FE, 'h5509);
    sec_probe(7, 'h4, 0, "R6 word write entry7");

    // R2: secondary sweep
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 3; k++)
        for (int w = 0; w < 2; w++)
          sec_probe(i, ofs_set[k], w[0], "R2 sec paged");

    // R7/R3/R10: window sweep
    for (int s = 0; s < 4; s++) begin
      if (s % 2 == 0) bus_wr(0, 'hA15105, 'hFC | s, s != win, "R7/R11 window byte");
      else            bus_wr(1, 'hA15104, 'h1230 | s, s != win, "R7/R11 window word");
      win = s;
      prim_probe(0, 0, 0, "R3 lo start");
      prim_probe('h7FFFF, 1, 0, "R3 lo end word");
      prim_probe('h80000, 0, 0, "R3 hi start");
      prim_probe('hFFFFF, 0, 0, "R3 hi end");
      @(negedge clk); p_addr = 24'h8FFFFF; #1;
      chk(p_hit == 0, "R10 below window", int'(p_hit), 0);
      @(negedge clk); p_addr = 24'hA00000; #1;
      chk(p_hit == 0, "R10 above window", int'(p_hit), 0);
    end
    // R7: writes elsewhere do not touch window; R11 same value -> no pulse
    bus_wr(0, 'hA15104, 'h01, 0, "R7 even byte no effect");
    prim_probe('h80000, 0, 0, "R7 window held");
    bus_wr(0, 'hA15105, 'h03, 0, "R11 same window no pulse");
    // R11: gating and update request
    rom_cached = 0;
    bus_wr(0, 'hA130F5, 'h09, 0, "R11 uncached no pulse");
    model_pg(0, 'hA130F5, 'h09);
    sec_probe(2, 0, 0, "R4 uncached write lands");
    rom_cached = 1;
    @(negedge clk); update_req = 1;
    @(negedge clk); update_req = 0;
    chk(inv_pulse == 1, "R11 update pulse", int'(inv_pulse), 1);
    @(negedge clk);
    chk(inv_pulse == 0, "R11 update pulse width", int'(inv_pulse), 0);

    // R8/R9: linear mode
    paged_mode = 0;
    rom_size = 25'h281234;
    rs_round = (('h281234 + 65535) / 65536) * 65536;
    for (int s = 0; s < 4; s++) begin
      bus_wr(0, 'hA15105, s, s != win, "R7 window write");
      win = s;
      prim_probe(0, 0, rs_round, "R8 linear start");
      prim_probe('h8FFFF, 0, rs_round, "R8 linear edge");
      prim_probe('h90000, 1, rs_round, "R8 linear past edge");
      prim_probe('hFFFFF, 0, rs_round, "R8 linear end");
    end
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 2; w++)
        sec_probe(i, 'h3579B, w[0], "R9 sec linear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule